// File: doc/BRIEF.md
# Supply window fault monitor

This block watches one digitized supply rail. Each time a new sample code arrives with its valid strobe, two independent limit detectors compare the sample against programmable under-voltage and over-voltage thresholds. An under-voltage flag is raised when the rail drops below its lower limit, and an over-voltage flag is raised when the rail rises above its upper limit. Once a flag is raised, a separate 5-bit hysteresis value moves that detector's release point away from the threshold. The flag therefore stays set until the rail has clearly recovered, so it does not toggle repeatedly near a threshold.

A polarity control lets the same detectors monitor a negative rail. In that mode they compare the magnitude of the sample, so a more negative rail counts as an over-voltage. A 2-bit select routes one of the following to the single fault output: the over-voltage flag, the under-voltage flag, their OR (an out-of-window fault), or a constant low. Scaling, analog conditioning and time-domain deglitching are done outside this block.

Top module: `supply_window_monitor`

## Requirements
- R1: While rst_ni is low, and after it is released until the first valid sample, uv_flag_o, ov_flag_o and fault_o are 0.
- R2: Both flags change only at a rising clock edge where sample_vld_i is 1. The new values appear after that edge. On edges without a valid strobe both flags hold.
- R3: An under-voltage flag that is clear becomes set when the sample magnitude is strictly less than uv_thresh_i. Equality does not set it.
- R4: A set under-voltage flag clears only when the magnitude is strictly greater than uv_thresh_i + uv_hyst_i. Otherwise it stays set.
- R5: An over-voltage flag that is clear becomes set when the magnitude is strictly greater than ov_thresh_i. Equality does not set it.
- R6: A set over-voltage flag clears only when the magnitude is strictly less than ov_thresh_i - ov_hyst_i. Otherwise it stays set.
- R7: The release level uv_thresh_i + uv_hyst_i saturates at 255, and ov_thresh_i - ov_hyst_i saturates at 0. As a result, a flag whose release level has saturated cannot clear.
- R8: With neg_mode_i = 0, sample_i is a 9-bit two's-complement code. A non-negative value is used directly as the magnitude, and a negative value is treated as magnitude 0.
- R9: With neg_mode_i = 1, the magnitude is the negation of sample_i. A non-negative sample gives magnitude 0, and -256 gives magnitude 255.
- R10: fault_o is driven combinationally from the current flags and fault_sel_i: 2'b00 selects the over-voltage flag, 2'b01 the under-voltage flag, 2'b10 their OR, and 2'b11 forces 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_vld_i | input | 1 | Sample strobe; flags update only on strobed edges |
| sample_i | input | 9 | Signed sample code |
| neg_mode_i | input | 1 | 1 selects negative-rail magnitude folding |
| uv_thresh_i | input | 8 | Under-voltage threshold code |
| ov_thresh_i | input | 8 | Over-voltage threshold code |
| uv_hyst_i | input | 5 | Under-voltage release offset |
| ov_hyst_i | input | 5 | Over-voltage release offset |
| fault_sel_i | input | 2 | Fault output select |
| uv_flag_o | output | 1 | Under-voltage status |
| ov_flag_o | output | 1 | Over-voltage status |
| fault_o | output | 1 | Selected fault |

## Verification
Both flags are registered, so each flag reflects a strobed sample right after the next rising edge, which is a latency of one cycle. fault_o is a combinational function of those flags and of fault_sel_i. A change to the select therefore shows up in the same cycle, with no extra latency. The bench drives every stimulus at a falling edge and queues the expected triple for that cycle. It then compares one time unit after the following rising edge, which matches both kinds of result. Hold and select-only cycles are queued exactly like strobed ones, so the bench confirms that the flags did not move.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {
    FSEL_OV  = 2'b00,
    FSEL_UV  = 2'b01,
    FSEL_WIN = 2'b10,
    FSEL_OFF = 2'b11
  } fault_sel_e;
endpackage

// File: rtl/swm_magnitude.sv
module swm_magnitude #(
  parameter int CODE_W = 8
) (
  input  logic signed [CODE_W:0]   sample_i,
  input  logic                     neg_i,
  output logic        [CODE_W-1:0] mag_o
);
  logic [CODE_W:0] negated;

  assign negated = -sample_i;

  always_comb begin
    if (!neg_i) begin
      mag_o = sample_i[CODE_W] ? '0 : sample_i[CODE_W-1:0];
    end else if (!sample_i[CODE_W]) begin
      mag_o = '0;
    end else begin
      // most negative code folds to full scale
      mag_o = negated[CODE_W] ? '1 : negated[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/swm_limit_det.sv
module swm_limit_det #(
  parameter int CODE_W = 8,
  parameter int HYST_W = 5,
  parameter bit OVER   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [CODE_W-1:0] mag_i,
  input  logic [CODE_W-1:0] thresh_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              flag_o
);
  localparam int SW = CODE_W + 1;

  logic [SW-1:0]     hyst_ext;
  logic [CODE_W-1:0] release_lvl;
  logic              trip, clear;
  logic              flag_q;

  assign hyst_ext = SW'(hyst_i);

  if (OVER) begin : g_over
    logic [SW-1:0] diff;
    assign diff        = {1'b0, thresh_i} - hyst_ext;
    assign release_lvl = diff[SW-1] ? '0 : diff[CODE_W-1:0];
    assign trip        = mag_i > thresh_i;
    assign clear       = mag_i < release_lvl;
  end else begin : g_under
    logic [SW-1:0] sum;
    assign sum         = {1'b0, thresh_i} + hyst_ext;
    assign release_lvl = sum[SW-1] ? '1 : sum[CODE_W-1:0];
    assign trip        = mag_i < thresh_i;
    assign clear       = mag_i > release_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (vld_i) begin
      if (!flag_q && trip)      flag_q <= 1'b1;
      else if (flag_q && clear) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/swm_fault_mux.sv
module swm_fault_mux
  import swm_pkg::*;
(
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic [1:0] sel_i,
  output logic       fault_o
);
  fault_sel_e sel;

  assign sel = fault_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      FSEL_OV:  fault_o = ov_i;
      FSEL_UV:  fault_o = uv_i;
      FSEL_WIN: fault_o = uv_i | ov_i;
      default:  fault_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/supply_window_monitor.sv
module supply_window_monitor #(
  parameter int CODE_W = 8,
  parameter int HYST_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_vld_i,
  input  logic signed [CODE_W:0]   sample_i,
  input  logic                     neg_mode_i,
  input  logic        [CODE_W-1:0] uv_thresh_i,
  input  logic        [CODE_W-1:0] ov_thresh_i,
  input  logic        [HYST_W-1:0] uv_hyst_i,
  input  logic        [HYST_W-1:0] ov_hyst_i,
  input  logic        [1:0]        fault_sel_i,
  output logic                     uv_flag_o,
  output logic                     ov_flag_o,
  output logic                     fault_o
);
  logic [CODE_W-1:0] mag;

  swm_magnitude #(.CODE_W(CODE_W)) u_mag (
    .sample_i (sample_i),
    .neg_i    (neg_mode_i),
    .mag_o    (mag)
  );

  swm_limit_det #(.CODE_W(CODE_W), .HYST_W(HYST_W), .OVER(1'b0)) u_uv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (sample_vld_i),
    .mag_i    (mag),
    .thresh_i (uv_thresh_i),
    .hyst_i   (uv_hyst_i),
    .flag_o   (uv_flag_o)
  );

  swm_limit_det #(.CODE_W(CODE_W), .HYST_W(HYST_W), .OVER(1'b1)) u_ov (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (sample_vld_i),
    .mag_i    (mag),
    .thresh_i (ov_thresh_i),
    .hyst_i   (ov_hyst_i),
    .flag_o   (ov_flag_o)
  );

  swm_fault_mux u_mux (
    .uv_i    (uv_flag_o),
    .ov_i    (ov_flag_o),
    .sel_i   (fault_sel_i),
    .fault_o (fault_o)
  );
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int CODE_W = 8,
  parameter int HYST_W = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_vld_i,
  input logic signed [CODE_W:0]   sample_i,
  input logic                     neg_mode_i,
  input logic        [CODE_W-1:0] uv_thresh_i,
  input logic        [CODE_W-1:0] ov_thresh_i,
  input logic        [HYST_W-1:0] uv_hyst_i,
  input logic        [HYST_W-1:0] ov_hyst_i,
  input logic        [1:0]        fault_sel_i,
  input logic                     uv_flag_o,
  input logic                     ov_flag_o,
  input logic                     fault_o
);
  logic pos_ok;
  assign pos_ok = !neg_mode_i && !sample_i[CODE_W];

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> ($stable(uv_flag_o) && $stable(ov_flag_o)));

  p_uv_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && pos_ok && (sample_i[CODE_W-1:0] < uv_thresh_i)) |=> uv_flag_o);

  p_uv_band_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && uv_flag_o && pos_ok && (sample_i[CODE_W-1:0] >= uv_thresh_i) &&
     ({1'b0, sample_i[CODE_W-1:0]} <= ({1'b0, uv_thresh_i} + (CODE_W+1)'(uv_hyst_i))))
    |=> uv_flag_o);

  p_ov_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && pos_ok && (sample_i[CODE_W-1:0] > ov_thresh_i)) |=> ov_flag_o);

  p_neg_fold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && neg_mode_i && !sample_i[CODE_W] && (uv_thresh_i != '0)) |=> uv_flag_o);

  p_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 2'b11) |-> !fault_o);

  p_window_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_sel_i == 2'b10) |-> (fault_o == (uv_flag_o | ov_flag_o)));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!uv_flag_o && !ov_flag_o);
    end
  end
endmodule

bind supply_window_monitor swm_checker #(.CODE_W(CODE_W), .HYST_W(HYST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_vld_i (sample_vld_i),
  .sample_i     (sample_i),
  .neg_mode_i   (neg_mode_i),
  .uv_thresh_i  (uv_thresh_i),
  .ov_thresh_i  (ov_thresh_i),
  .uv_hyst_i    (uv_hyst_i),
  .ov_hyst_i    (ov_hyst_i),
  .fault_sel_i  (fault_sel_i),
  .uv_flag_o    (uv_flag_o),
  .ov_flag_o    (ov_flag_o),
  .fault_o      (fault_o)
);

// File: tb/supply_window_monitor_bench.sv
`timescale 1ns/1ps
module supply_window_monitor_bench;
  typedef struct {
    logic  uv;
    logic  ov;
    logic  f;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vld = 1'b0;
  logic signed [8:0] smp = '0;
  logic              neg = 1'b0;
  logic [7:0]        uvt = '0, ovt = '0;
  logic [4:0]        uvh = '0, ovh = '0;
  logic [1:0]        sel = '0;
  logic              uv_o, ov_o, f_o;

  int c_uvt = 100, c_ovt = 200, c_uvh = 10, c_ovh = 20, c_sel = 2;
  logic c_neg = 1'b0;
  logic m_uv = 1'b0, m_ov = 1'b0;
  int vectors = 0, errors = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  supply_window_monitor u_supply_window_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .sample_i(smp),
    .neg_mode_i(neg), .uv_thresh_i(uvt), .ov_thresh_i(ovt),
    .uv_hyst_i(uvh), .ov_hyst_i(ovh), .fault_sel_i(sel),
    .uv_flag_o(uv_o), .ov_flag_o(ov_o), .fault_o(f_o)
  );

  function automatic int fold(int s, logic n);
    if (!n) return (s < 0) ? 0 : s;
    if (s >= 0) return 0;
    return (-s > 255) ? 255 : -s;
  endfunction

  task automatic step(input logic v, input int s, input string tag);
    int m, up, dn;
    exp_t e;
    @(negedge clk);
    vld = v; smp = 9'(s); neg = c_neg;
    uvt = 8'(c_uvt); ovt = 8'(c_ovt); uvh = 5'(c_uvh); ovh = 5'(c_ovh); sel = 2'(c_sel);
    m  = fold(s, c_neg);
    up = (c_uvt + c_uvh > 255) ? 255 : c_uvt + c_uvh;
    dn = (c_ovt - c_ovh < 0) ? 0 : c_ovt - c_ovh;
    if (v) begin
      if (!m_uv && m < c_uvt) m_uv = 1'b1;
      else if (m_uv && m > up) m_uv = 1'b0;
      if (!m_ov && m > c_ovt) m_ov = 1'b1;
      else if (m_ov && m < dn) m_ov = 1'b0;
    end
    e.uv = m_uv; e.ov = m_ov; e.tag = tag;
    case (c_sel)
      0: e.f = m_ov;
      1: e.f = m_uv;
      2: e.f = m_uv | m_ov;
      default: e.f = 1'b0;
    endcase
    q.push_back(e);
  endtask

  // monitor: compares one unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if ({uv_o, ov_o, f_o} !== {e.uv, e.ov, e.f}) begin
          errors++;
          $display("FAIL %s: uv/ov/fault got %b%b%b exp %b%b%b",
                   e.tag, uv_o, ov_o, f_o, e.uv, e.ov, e.f);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if ({uv_o, ov_o, f_o} !== 3'b000) begin
      errors++;
      $display("FAIL R1: in reset got %b%b%b exp 000", uv_o, ov_o, f_o);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    vectors++;
    if ({uv_o, ov_o, f_o} !== 3'b000) begin
      errors++;
      $display("FAIL R1: after release got %b%b%b exp 000", uv_o, ov_o, f_o);
    end

    step(1, 150, "R3");
    step(1, 100, "R3");  // equality does not trip
    step(1, 99,  "R3");
    step(0, 150, "R2");  // no strobe, flag holds
    step(0, 250, "R2");
    step(1, 105, "R4");
    step(1, 110, "R4");  // at release level, holds
    step(1, 111, "R4");
    step(1, 200, "R5");
    step(1, 201, "R5");
    step(1, 181, "R6");
    step(1, 180, "R6");
    step(1, 179, "R6");

    c_ovt = 10; c_ovh = 31;
    step(1, 11, "R7");
    step(1, 0,  "R7");   // release level clamps to 0
    c_uvt = 250; c_uvh = 31;
    step(1, 255, "R7");  // release level clamps to 255
    c_uvt = 100; c_uvh = 0; c_ovt = 200; c_ovh = 0;
    step(1, 150, "R7");
    step(1, 150, "R8");
    step(1, -5,  "R8");
    step(1, 150, "R8");

    c_neg = 1'b1;
    step(1, -150, "R9");
    step(1, -256, "R9");
    step(1, -150, "R9");
    step(1, 50,   "R9");
    step(1, -150, "R9");
    c_neg = 1'b0;
    step(1, 220, "R10");
    c_sel = 0; step(0, 0, "R10");
    c_sel = 1; step(0, 0, "R10");
    c_sel = 2; step(0, 0, "R10");
    c_sel = 3; step(0, 0, "R10");
    step(1, 50, "R10");
    c_sel = 1; step(0, 0, "R10");
    c_sel = 0; step(0, 0, "R10");

    repeat (3) @(posedge clk);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule